// File: doc/BRIEF.md
# I2C Bus Time-out Monitor

This block listens passively to the SCL and SDA wires of an I2C bus and reports two stuck-bus conditions as sticky flags. The event flag is raised when no bus event has been seen for longer than a programmed number of system clocks. A bus event is a Start, a Stop, or either edge of SCL. The event timer is held at zero while the bus-idle input is high, so a quiet idle bus never reports a time-out. The SCL flag is raised when SCL has stayed low longer than the same programmed count, whatever the state of the bus-idle input.

Both wires first pass through a two-stage synchroniser. Edge, Start and Stop detection then run on the synchronised copies. The flags behave like a status register: writing a 1 to a flag's bit clears it, and writing a 0 leaves it alone. If a time-out trips in the same cycle as a clear, the time-out wins. A single interrupt output is the OR of each flag gated by its own enable bit.

Top module: `i2c_timeout_watch`

## Requirements
- R1: With the bus not idle and a non-zero count N on `timeout_val`, `evt_to_flag` reads 0 through the N+3rd rising clock edge after an SCL or SDA input change that forms an event, and reads 1 after the N+4th edge. The extra cycles are two synchroniser stages plus edge detection.
- R2: Each SCL edge, rising or falling, restarts the event timer. SCL toggling with a half period shorter than N keeps `evt_to_flag` at 0.
- R3: A Start restarts the event timer, and so does a Stop. A Start is SDA falling while SCL is high, and a Stop is SDA rising while SCL is high. An SDA change while SCL is low does not restart the event timer.
- R4: While `bus_idle` is 1, the event timer holds at zero and `evt_to_flag` never sets. When `bus_idle` drops to 0 with no further event, the flag reads 0 after the Nth edge and 1 after the N+1st edge.
- R5: When the SCL input goes low, `scl_to_flag` reads 0 after the N+2nd edge and 1 after the N+3rd edge, independent of `bus_idle`. Any high level on SCL restarts this timer.
- R6: A `timeout_val` of 0 holds both timers at zero, so neither flag sets.
- R7: Both flags are sticky. A cycle with `clr_wr`=1 clears each flag whose bit in `clr_data` is 1; the bit order is bit 0 for the event flag and bit 1 for the SCL flag. A 0 bit, or `clr_wr`=0, leaves the flag unchanged.
- R8: A time-out that trips in the same cycle as a clear of that flag leaves the flag set.
- R9: `irq` = (`evt_to_flag` AND `int_en[0]`) OR (`scl_to_flag` AND `int_en[1]`).
- R10: After reset both flags and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | SCL wire level, asynchronous |
| sda_in | input | 1 | SDA wire level, asynchronous |
| bus_idle | input | 1 | 1 when no master owns the bus |
| timeout_val | input | TO_W (16) | Time-out count in clocks; 0 disables both timers |
| int_en | input | 2 | Interrupt enables: bit 0 for the event flag, bit 1 for the SCL flag |
| clr_wr | input | 1 | Clear-write strobe |
| clr_data | input | 2 | Write-one-to-clear data, with the same bit order as `int_en` |
| evt_to_flag | output | 1 | Sticky event time-out flag |
| scl_to_flag | output | 1 | Sticky SCL-low time-out flag |
| irq | output | 1 | Gated interrupt |

## Verification
Five stimulus patterns are used:
- A run of SCL toggles, then silence. This separates a timer that every SCL edge restarts from one that only a single edge direction restarts, and it pins the exact trip cycle.
- Start and Stop, each as the only event. These show that SDA transitions with SCL high are recognised as events.
- SDA wiggling while SCL is low. This shows that such changes do not restart the timer.
- SCL held low with the bus marked idle, including a short high pulse. This separates the two timers and confirms that the SCL timer ignores the idle input.
- A zero count, clears placed on the trip cycle, and enable combinations. These cover the disable, set-over-clear priority and interrupt gating.

// File: rtl/i2c_to_pkg.sv
// Shared definitions for the I2C time-out monitor.
// Assumes exactly two flags: the event time-out and the SCL-low time-out.
package i2c_to_pkg;
    localparam int NFLAG    = 2;
    localparam int FLAG_EVT = 0;
    localparam int FLAG_SCL = 1;

    typedef logic [NFLAG-1:0] flag_vec_t;

    // Decoded bus events for one clock cycle.
    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;
endpackage

// File: rtl/i2c_to_sync.sv
// Multi-stage synchroniser for asynchronous bus wires.
// Assumes STAGES >= 2. Reset value is 1, the pulled-up level of an idle bus.
module i2c_to_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift each wire through its flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], din[b]};
        end

        assign dout[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/i2c_to_evdet.sv
// Bus event detector: SCL edges, Start (SDA falls while SCL is high)
// and Stop (SDA rises while SCL is high).
// Assumes synchronised inputs. Holds one cycle of history.
module i2c_to_evdet
    import i2c_to_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t ev,
    output logic     any_evt
);
    logic scl_q, sda_q;

    // Keep the previous synchronised levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Decode edges and conditions from the current and previous levels.
    always_comb begin
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
        any_evt     = ev.scl_rise | ev.scl_fall | ev.start | ev.stop;
    end
endmodule

// File: rtl/i2c_to_timer.sv
// Saturating time-out counter. It counts clocks since the last restart.
// It pulses trip in the cycle the count equals a non-zero limit.
// Assumes the limit is stable while the counter runs.
module i2c_to_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         trip
);
    logic [W-1:0] cnt;

    // Count up from zero after each restart and hold at full scale.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (restart)    cnt <= '0;
        else if (cnt != '1)  cnt <= cnt + 1'b1;
    end

    // Signal expiry when the count reaches the limit.
    always_comb trip = !restart && (limit != '0) && (cnt == limit);
endmodule

// File: rtl/i2c_timeout_watch.sv
// I2C bus time-out monitor top level.
// It synchronises SCL/SDA, decodes bus events and runs two timers:
// an event timer that is held while the bus is idle, and an SCL-low timer.
// It keeps sticky write-one-to-clear flags and a gated interrupt.
// Assumes timeout_val, int_en and bus_idle are synchronous to clk.
module i2c_timeout_watch
    import i2c_to_pkg::*;
#(
    parameter int TO_W        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             bus_idle,
    input  logic [TO_W-1:0]  timeout_val,
    input  logic [NFLAG-1:0] int_en,
    input  logic             clr_wr,
    input  logic [NFLAG-1:0] clr_data,
    output logic             evt_to_flag,
    output logic             scl_to_flag,
    output logic             irq
);
    localparam int LINE_W = 2;

    logic [LINE_W-1:0] lines_s;
    logic              scl_s, sda_s;
    bus_evt_t          ev;
    logic              any_evt;
    logic              tv_zero;
    logic              evt_restart, scl_restart;
    logic              evt_trip, scl_trip;
    flag_vec_t         trip_v;
    flag_vec_t         flag_q;

    i2c_to_sync #(.W(LINE_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sda_in, scl_in}),
        .dout (lines_s)
    );

    assign scl_s = lines_s[0];
    assign sda_s = lines_s[1];

    i2c_to_evdet u_evdet (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_s  (scl_s),
        .sda_s  (sda_s),
        .ev     (ev),
        .any_evt(any_evt)
    );

    // Derive the restart conditions for both timers.
    always_comb begin
        tv_zero     = (timeout_val == '0);
        evt_restart = any_evt | bus_idle | tv_zero;
        scl_restart = scl_s | tv_zero;
    end

    i2c_to_timer #(.W(TO_W)) u_evt_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(evt_restart),
        .limit  (timeout_val),
        .trip   (evt_trip)
    );

    i2c_to_timer #(.W(TO_W)) u_scl_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(scl_restart),
        .limit  (timeout_val),
        .trip   (scl_trip)
    );

    assign trip_v[FLAG_EVT] = evt_trip;
    assign trip_v[FLAG_SCL] = scl_trip;

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        // Sticky flag: a trip sets it, a write-one clears it, and set wins.
        always_ff @(posedge clk) begin
            if (!rst_n)                      flag_q[i] <= 1'b0;
            else if (trip_v[i])              flag_q[i] <= 1'b1;
            else if (clr_wr && clr_data[i])  flag_q[i] <= 1'b0;
        end
    end

    // Drive the outputs from the flags and the enable mask.
    always_comb begin
        evt_to_flag = flag_q[FLAG_EVT];
        scl_to_flag = flag_q[FLAG_SCL];
        irq         = |(flag_q & int_en);
    end
endmodule

// File: rtl/i2c_timeout_watch_chk.sv
// Assertion checker for the I2C time-out monitor, bound to the top module.
module i2c_timeout_watch_chk
    import i2c_to_pkg::*;
#(
    parameter int TO_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_idle,
    input logic [TO_W-1:0]  timeout_val,
    input logic [NFLAG-1:0] int_en,
    input logic             clr_wr,
    input logic [NFLAG-1:0] clr_data,
    input logic             evt_to_flag,
    input logic             scl_to_flag,
    input logic             irq,
    input logic             evt_trip,
    input logic             scl_trip
);
    // R7: a flag only falls after a write-one to its bit.
    assert_clear_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(evt_to_flag) |-> $past(clr_wr && clr_data[FLAG_EVT]));

    // R7: the same rule for the SCL flag.
    assert_scl_clear_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_to_flag) |-> $past(clr_wr && clr_data[FLAG_SCL]));

    // R8: a trip always leaves the flag set, even with a clear that cycle.
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(evt_trip) |-> evt_to_flag);

    // R8: the same for the SCL flag.
    assert_scl_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(scl_trip) |-> scl_to_flag);

    // R4: the event flag never rises from a cycle with the bus idle.
    assert_idle_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_to_flag) |-> !$past(bus_idle));

    // R6: a zero count cannot produce a time-out.
    assert_zero_disables_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(evt_to_flag) || $rose(scl_to_flag)) |-> ($past(timeout_val) != '0));

    // R9: an enabled, set flag asserts the interrupt.
    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((scl_to_flag && int_en[FLAG_SCL]) || (evt_to_flag && int_en[FLAG_EVT])) |-> irq);
endmodule

bind i2c_timeout_watch i2c_timeout_watch_chk #(.TO_W(TO_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_idle   (bus_idle),
    .timeout_val(timeout_val),
    .int_en     (int_en),
    .clr_wr     (clr_wr),
    .clr_data   (clr_data),
    .evt_to_flag(evt_to_flag),
    .scl_to_flag(scl_to_flag),
    .irq        (irq),
    .evt_trip   (evt_trip),
    .scl_trip   (scl_trip)
);

// File: tb/test_i2c_timeout_watch.sv
module test_i2c_timeout_watch;
    localparam int TV = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_in = 1'b1;
    logic        sda_in = 1'b1;
    logic        bus_idle = 1'b1;
    logic [15:0] timeout_val = '0;
    logic [1:0]  int_en = '0;
    logic        clr_wr = 1'b0;
    logic [1:0]  clr_data = '0;
    logic        evt_to_flag, scl_to_flag, irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    i2c_timeout_watch i_i2c_timeout_watch (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .bus_idle(bus_idle), .timeout_val(timeout_val), .int_en(int_en),
        .clr_wr(clr_wr), .clr_data(clr_data),
        .evt_to_flag(evt_to_flag), .scl_to_flag(scl_to_flag), .irq(irq)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Wait n rising edges, then move to the following falling edge.
    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_all();
        timeout_val = '0;
        scl_in = 1'b1; sda_in = 1'b1; bus_idle = 1'b1;
        clr_wr = 1'b1; clr_data = 2'b11;
        cyc(1);
        clr_wr = 1'b0; clr_data = 2'b00;
        cyc(4);
    endtask

    task automatic t_reset();
        chk("R10 evt after reset", evt_to_flag, 1'b0);
        chk("R10 scl after reset", scl_to_flag, 1'b0);
        chk("R10 irq after reset", irq, 1'b0);
    endtask

    task automatic t_scl_toggle();
        clear_all();
        bus_idle = 1'b0; timeout_val = TV;
        for (int k = 0; k < 10; k++) begin
            scl_in = ~scl_in;
            cyc(8);
            chk("R2 toggling keeps evt clear", evt_to_flag, 1'b0);
        end
        scl_in = 1'b1;
        cyc(1);
        // The last toggle left SCL high; restart the count from a fresh rise.
        scl_in = 1'b0; cyc(3); scl_in = 1'b1;
        cyc(TV + 3);
        chk("R1 evt low at N+3", evt_to_flag, 1'b0);
        cyc(1);
        chk("R1 evt high at N+4", evt_to_flag, 1'b1);
        chk("R5 short low no scl flag", scl_to_flag, 1'b0);
    endtask

    task automatic t_start_stop();
        clear_all();
        bus_idle = 1'b0; timeout_val = TV;
        cyc(10);
        sda_in = 1'b0;                        // Start
        cyc(TV + 3);
        chk("R3 start restart low", evt_to_flag, 1'b0);
        cyc(1);
        chk("R3 start restart high", evt_to_flag, 1'b1);

        clear_all();
        sda_in = 1'b0; cyc(4);
        bus_idle = 1'b0; timeout_val = TV;
        cyc(10);
        sda_in = 1'b1;                        // Stop
        cyc(TV + 3);
        chk("R3 stop restart low", evt_to_flag, 1'b0);
        cyc(1);
        chk("R3 stop restart high", evt_to_flag, 1'b1);

        clear_all();
        bus_idle = 1'b0; timeout_val = TV;
        scl_in = 1'b0;
        cyc(5); sda_in = 1'b0;
        cyc(5); sda_in = 1'b1;
        cyc(TV + 3 - 10);
        chk("R3 sda with scl low no restart (low)", evt_to_flag, 1'b0);
        cyc(1);
        chk("R3 sda with scl low no restart (high)", evt_to_flag, 1'b1);
    endtask

    task automatic t_idle();
        clear_all();
        timeout_val = TV; bus_idle = 1'b1;
        cyc(60);
        chk("R4 idle no evt flag", evt_to_flag, 1'b0);
        bus_idle = 1'b0;
        cyc(TV);
        chk("R4 after idle low at N", evt_to_flag, 1'b0);
        cyc(1);
        chk("R4 after idle high at N+1", evt_to_flag, 1'b1);
    endtask

    task automatic t_scl_low();
        clear_all();
        timeout_val = TV; bus_idle = 1'b1;
        scl_in = 1'b0; cyc(15);
        scl_in = 1'b1; cyc(4);
        scl_in = 1'b0;
        cyc(TV + 2);
        chk("R5 scl low at N+2", scl_to_flag, 1'b0);
        cyc(1);
        chk("R5 scl high at N+3", scl_to_flag, 1'b1);
        chk("R4 scl low while idle no evt", evt_to_flag, 1'b0);
    endtask

    task automatic t_zero();
        clear_all();
        bus_idle = 1'b0; scl_in = 1'b0;
        cyc(100);
        chk("R6 zero no evt", evt_to_flag, 1'b0);
        chk("R6 zero no scl", scl_to_flag, 1'b0);
        timeout_val = TV;
        cyc(TV);
        chk("R6 enabled scl low at N", scl_to_flag, 1'b0);
        cyc(1);
        chk("R6 enabled scl high at N+1", scl_to_flag, 1'b1);
        chk("R6 enabled evt high at N+1", evt_to_flag, 1'b1);
    endtask

    task automatic t_clear_irq();
        // Both flags are set on entry (from t_zero).
        timeout_val = '0;
        int_en = 2'b00; cyc(1);
        chk("R9 no enable no irq", irq, 1'b0);
        int_en = 2'b10; cyc(1);
        chk("R9 scl enabled irq", irq, 1'b1);
        clr_wr = 1'b0; clr_data = 2'b11; cyc(1);
        chk("R7 no strobe evt kept", evt_to_flag, 1'b1);
        chk("R7 no strobe scl kept", scl_to_flag, 1'b1);
        clr_wr = 1'b1; clr_data = 2'b10; cyc(1);
        clr_wr = 1'b0; clr_data = 2'b00;
        chk("R7 scl cleared", scl_to_flag, 1'b0);
        chk("R7 evt untouched by 0 bit", evt_to_flag, 1'b1);
        chk("R9 scl clear drops irq", irq, 1'b0);
        int_en = 2'b01; cyc(1);
        chk("R9 evt enabled irq", irq, 1'b1);
        clr_wr = 1'b1; clr_data = 2'b01; cyc(1);
        clr_wr = 1'b0; clr_data = 2'b00;
        chk("R7 evt cleared", evt_to_flag, 1'b0);
        chk("R9 irq clear", irq, 1'b0);
        int_en = 2'b00;
    endtask

    task automatic t_set_wins();
        clear_all();
        bus_idle = 1'b0; timeout_val = TV;
        scl_in = 1'b0; cyc(3); scl_in = 1'b1;
        cyc(TV + 3);
        clr_wr = 1'b1; clr_data = 2'b01;
        cyc(1);
        clr_wr = 1'b0; clr_data = 2'b00;
        chk("R8 set wins over clear", evt_to_flag, 1'b1);
        cyc(2);
        chk("R8 flag stays set", evt_to_flag, 1'b1);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_scl_toggle();
        t_start_stop();
        t_idle();
        t_scl_low();
        t_zero();
        t_clear_irq();
        t_set_wins();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule